// File: doc/BRIEF.md
# Signed Successive-Approximation Search Engine

This block drives the bit-by-bit search of a converter that resolves a sign and twelve magnitude bits. A sequencer pulses `start_i`. The engine first runs one polarity trial with the trial level at ground. It then runs twelve magnitude trials, from the most significant bit down to the least. The trial level, `trial_mag_o`, goes to an external DAC. A single comparator bit, `cmp_i`, comes back. Each trial uses exactly one clock, and the comparator bit is taken on the clock edge that closes that trial.

During the magnitude trials of a negative search, `trial_neg_o` is high. This tells the analog side to compare the ones'-complement magnitude of the held input, which is -input-1, against the trial level. The resolved bits are then folded into a 13-bit two's-complement word. No adder and no clamp are needed for this. The word covers -4096 to +4095, and a new result is announced with a one-cycle done pulse. The DAC, the comparator and any correction arithmetic stay outside the block.

Top module: `sar_engine`

## Requirements
- R1: In the cycle after `start_i` is sampled, the engine is in its polarity trial. `pol_phase_o` is 1 and `trial_mag_o` is 0 (ground).
- R2: If `cmp_i` is high at the end of the polarity trial, the input is taken as positive and result bit 12 is 0. If it is low, the input is negative and bit 12 is 1. The sign stays fixed through the magnitude trials.
- R3: The first magnitude trial presents 0x800. Every later trial presents the bits kept so far plus the next lower bit. There are twelve trials, one per clock.
- R4: A magnitude bit is kept exactly when `cmp_i` is high in the cycle of its trial.
- R5: A positive search returns {0, magnitude}, which is 0 to +4095.
- R6: A negative search returns {1, bitwise-inverse of magnitude}, which is -1 to -4096. `trial_neg_o` is high throughout its magnitude trials. `result_o` changes only when a search completes.
- R7: A `start_i` pulse during a search abandons it and begins a new polarity trial. The abandoned search produces no done pulse.
- R8: `busy_o` rises the cycle after start and stays high for 13 cycles. It falls in the same cycle that `result_o` loads, when `done_o` pulses high for exactly one cycle.
- R9: If `start_i` coincides with the final bit decision, the finished result still loads with a done pulse. The new search begins at once and `busy_o` stays high.
- R10: Under reset, `busy_o`, `done_o`, `pol_phase_o`, `trial_neg_o`, `trial_mag_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the sequencer |
| cmp_i | input | 1 | Comparator: held input above trial level |
| pol_phase_o | output | 1 | Polarity trial in progress (DAC at ground) |
| trial_neg_o | output | 1 | Magnitude trials of a negative input |
| trial_mag_o | output | 12 | Trial magnitude presented to the DAC |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse with a new result |
| result_o | output | 13 | Two's-complement result |

## Verification
The final bit decision and a fresh start can land on the same clock edge. In that cycle the engine must both load the finished word and open a new polarity trial. The bench provokes this by raising `start_i` in the cycle before the last decision edge. It keeps the old held input in place for that decision and swaps in the new input only before the next polarity decision. The bench then judges the outcome in three ways. A done pulse must carry the first value. `busy_o` must stay high with `pol_phase_o` set. The second result must arrive 13 cycles later and match its own input.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Search phase of the engine
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_POL  = 2'd1,
        PH_MAG  = 2'd2
    } phase_e;

    // True in any phase that drives a trial onto the DAC
    function automatic logic in_search(input phase_e p);
        return (p == PH_POL) || (p == PH_MAG);
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAG_W - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (start_i) begin
            phase_q <= PH_POL;
            idx_q   <= TOP_IDX;
        end else begin
            unique case (phase_q)
                PH_POL: begin
                    phase_q <= PH_MAG;
                    idx_q   <= TOP_IDX;
                end
                PH_MAG: begin
                    if (idx_q == '0) phase_q <= PH_IDLE;
                    else             idx_q   <= idx_q - IDX_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
    assign last_o  = (phase_q == PH_MAG) && (idx_q == '0);

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (phase_q == PH_POL)); // R7

    AST_POL_THEN_MSB: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POL && !start_i) |=> (phase_q == PH_MAG && idx_q == TOP_IDX)); // R3

endmodule

// File: rtl/sar_trial.sv
module sar_trial
    import sar_pkg::*;
#(
    parameter int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    input  phase_e           phase_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] kept_o,
    output logic [MAG_W-1:0] trial_o,
    output logic             neg_o
);

    logic             sign_q;
    logic [MAG_W-1:0] kept;
    logic [MAG_W-1:0] sel;

    // One decision flop per magnitude bit
    for (genvar b = 0; b < MAG_W; b++) begin : g_bit
        logic bit_q;
        assign sel[b] = (phase_i == PH_MAG) && (idx_i == IDX_W'(b));
        always_ff @(posedge clk) begin
            if (rst || start_i)  bit_q <= 1'b0;
            else if (sel[b])     bit_q <= cmp_i;
        end
        assign kept[b] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst || start_i)          sign_q <= 1'b0;
        else if (phase_i == PH_POL)  sign_q <= ~cmp_i;
    end

    assign sign_o  = sign_q;
    assign kept_o  = kept;
    assign trial_o = kept | sel;
    assign neg_o   = sign_q && (phase_i == PH_MAG);

    AST_POL_AT_GROUND: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_POL) |-> (trial_o == '0)); // R1

    AST_SIGN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_MAG && $past(phase_i) == PH_MAG) |-> $stable(sign_q)); // R2

    AST_ONE_NEW_BIT: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_MAG) |-> ($countones(trial_o & ~kept) == 1)); // R3

endmodule

// File: rtl/sar_result.sv
module sar_result #(
    parameter int MAG_W = 12,
    localparam int RES_W = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last_i,
    input  logic             cmp_i,
    input  logic             sign_i,
    input  logic [MAG_W-1:0] kept_i,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);

    logic [MAG_W-1:0] final_mag;
    logic [RES_W-1:0] code;
    logic [RES_W-1:0] result_q;
    logic             done_q;

    // Merge the last decision straight from the comparator
    assign final_mag = {kept_i[MAG_W-1:1], cmp_i};
    // Negative: -(m+1) equals the bitwise inverse of m with the sign set
    assign code = sign_i ? {1'b1, ~final_mag} : {1'b0, final_mag};

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last_i;
            if (last_i) result_q <= code;
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !last_i |=> $stable(result_q)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int MAG_W = 12,
    localparam int IDX_W = $clog2(MAG_W),
    localparam int RES_W = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic             pol_phase_o,
    output logic             trial_neg_o,
    output logic [MAG_W-1:0] trial_mag_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             sign;
    logic [MAG_W-1:0] kept;

    sar_seq #(.MAG_W(MAG_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .phase_o (phase),
        .idx_o   (idx),
        .last_o  (last)
    );

    sar_trial #(.MAG_W(MAG_W)) u_trial (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cmp_i   (cmp_i),
        .phase_i (phase),
        .idx_i   (idx),
        .sign_o  (sign),
        .kept_o  (kept),
        .trial_o (trial_mag_o),
        .neg_o   (trial_neg_o)
    );

    sar_result #(.MAG_W(MAG_W)) u_result (
        .clk      (clk),
        .rst      (rst),
        .last_i   (last),
        .cmp_i    (cmp_i),
        .sign_i   (sign),
        .kept_i   (kept),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign pol_phase_o = (phase == PH_POL);
    assign busy_o      = in_search(phase);

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R8

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o)); // R8

endmodule

// File: tb/sar_engine_tb.sv
`timescale 1ns/1ps
module sar_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cmp;
    logic        pol_phase;
    logic        trial_neg;
    logic [11:0] trial_mag;
    logic        busy;
    logic        done;
    logic [12:0] result;

    int held;
    int n_chk  = 0;
    int n_fail = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sar_engine dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cmp_i       (cmp),
        .pol_phase_o (pol_phase),
        .trial_neg_o (trial_neg),
        .trial_mag_o (trial_mag),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result)
    );

    // Comparator model: held input sits half an LSB above its integer code
    always_comb begin
        if (pol_phase)      cmp = (held >= 0);
        else if (trial_neg) cmp = ((-held - 1) >= int'(trial_mag));
        else                cmp = (held >= int'(trial_mag));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mag_ref(input int v);
        return (v >= 0) ? v : (-v - 1);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", int'($signed(result)), 0);
            end else begin
                automatic int e = exp_q.pop_front();
                check(int'($signed(result)) == e, (e < 0) ? "R6 R2 result" : "R5 R4 result",
                      int'($signed(result)), e);
            end
        end
    end

    task automatic convert(input int v, input bit trace);
        @(negedge clk);
        held = v; start = 1'b1; exp_q.push_back(v);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        check(pol_phase == 1'b1 && trial_mag == 12'h000, "R1 polarity trial", int'(trial_mag), 0);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (trace) begin
                automatic int bt  = 11 - j;
                automatic int exp = (mag_ref(v) & ~((1 << (bt + 1)) - 1) & 12'hFFF) | (1 << bt);
                check(int'(trial_mag) == exp, "R3 trial code", int'(trial_mag), exp);
                check(trial_neg == (v < 0), "R6 negative flag", int'(trial_neg), int'(v < 0));
            end
            if (j == 11) check(busy == 1'b1, "R8 busy through last trial", int'(busy), 1);
        end
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b1, "R8 busy drops with done", int'(busy), 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; held = 0;
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && result == 0 && trial_mag == 0
              && pol_phase == 0 && trial_neg == 0, "R10 reset state", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0, "R10 idle after reset", int'(busy), 0);

        convert(1445, 1'b1);
        convert(-1234, 1'b1);
        convert(0, 1'b0);
        convert(4095, 1'b1);
        convert(-4096, 1'b1);
        convert(-1, 1'b0);
        convert(1, 1'b0);
        convert(2048, 1'b0);
        convert(-2048, 1'b0);
        convert(2047, 1'b0);

        // R6: result holds while idle
        repeat (3) @(negedge clk);
        check(int'($signed(result)) == 2047, "R6 result holds", int'($signed(result)), 2047);

        // R7: abort mid-search, only the second search reports
        @(negedge clk);
        held = -700; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        held = 3000; start = 1'b1; exp_q.push_back(3000);
        @(negedge clk);
        start = 1'b0;
        check(pol_phase == 1'b1, "R7 restart polarity", int'(pol_phase), 1);
        repeat (13) @(negedge clk);
        check(busy == 1'b0, "R7 restarted search ends", int'(busy), 0);

        // R9: start coincides with final decision
        @(negedge clk);
        held = -3333; start = 1'b1; exp_q.push_back(-3333);
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        start = 1'b1; exp_q.push_back(1777);
        @(negedge clk);
        start = 1'b0; held = 1777;
        check(done == 1'b1 && busy == 1'b1 && pol_phase == 1'b1, "R9 done with new start",
              int'(busy), 1);
        repeat (13) @(negedge clk);
        check(busy == 1'b0, "R9 second search ends", int'(busy), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule